// File: doc/BRIEF.md
# DMA Channel Register File

This block is the host-side register file of a four-channel DMA controller whose host data port is eight bits wide. Each channel keeps a 16-bit transfer address and a 16-bit transfer count. Software reaches these values one byte at a time through a single port per value. A byte-pointer state machine, shared by all channels and all address/count ports, decides whether an access hits the low byte or the high byte. The same register space also holds the mask controls, the per-channel mode bytes, a request register with a readable status byte, a pointer-clear command and a master clear.

The host selects a register with a 4-bit offset and strobes `wr_en` or `rd_en` for one clock. Writes take effect at that clock edge. Read data is combinational and is valid while `rd_en` is high. If both strobes are high together, the write wins. The transfer engine takes the per-channel address, count, mode and mask from the output ports.

The byte pointer is a two-state machine. `PTR_LO` is the reset state. It moves to `PTR_HI` on any address or count access (transition *advance*). `PTR_HI` returns to `PTR_LO` on the next such access (transition *wrap*). A pointer-clear write or a master-clear write forces `PTR_LO` from either state (transition *force-low*). The write decode is a second enumeration that maps each offset to one operation, such as address byte, count byte, single mask or mode.

Top module: `dma_regfile`

## Requirements
- R1: After reset every mask bit is 1, the byte pointer is on the low byte, all addresses, counts and modes are 0, and a status read returns 0x00.
- R2: Offset 2n (address) and offset 2n+1 (count) write one byte of channel n's 16-bit value: the low byte when the pointer is low and the high byte when it is high. The new value appears on `cur_addr`/`cur_cnt` slice n after the write edge.
- R3: A read of offset 2n or 2n+1 returns the low or high byte of channel n's current address or count, as chosen by the byte pointer.
- R4: One pointer serves all channels. Every read or write of offsets 0–7 toggles it, whichever channel or value is accessed.
- R5: Any write to offset 12 puts the pointer on the low byte, whatever the data.
- R6: A write to offset 10 sets channel wdata[1:0]'s mask bit to wdata[2] and leaves the other mask bits unchanged.
- R7: A write to offset 11 stores wdata[7:2] as the mode of channel wdata[1:0] (`mode_out` slice n, 6 bits). The other channels' modes are unchanged.
- R8: Any write to offset 14 clears all four mask bits.
- R9: A write to offset 15 loads the mask bits from wdata[3:0] (bit n for channel n).
- R10: A write to offset 13 sets all mask bits, puts the pointer on the low byte and clears the request bits. Addresses, counts and modes are kept.
- R11: A write to offset 9 sets channel wdata[1:0]'s request bit to wdata[2]. A read of offset 8 returns the request bits in [7:4] (bit 4+n for channel n) and 0 in [3:0].
- R12: A read of offset 13 returns 0x00. Reads and writes of offsets 8–15 never move the byte pointer, except the forced clears of R5 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, valid while rd_en is high |
| cur_addr | output | 64 | Channel n current address in bits [16n+15:16n] |
| cur_cnt | output | 64 | Channel n current count in bits [16n+15:16n] |
| mode_out | output | 24 | Channel n mode in bits [6n+5:6n] |
| mask_out | output | 4 | Per-channel mask, bit n for channel n |

## Verification
The bench interleaves byte accesses to different channels and to both address and count ports. A design with a pointer per channel or per port would then put the second byte into the low half instead of the high half. Pointer clears are written with nonzero data and issued from the high state, which exposes a clear that depends on its data or that only toggles the pointer. Single-mask and mode writes target a middle channel and then compare the whole mask or mode vector, so a wrong channel decode or a write that disturbs neighbouring channels shows up. Master clear is issued with the pointer high, requests pending and addresses loaded, which catches a clear that misses the pointer or the requests, or one that wipes the addresses.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;

    localparam int CH_NUM   = 4;
    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int SEL_W    = 4;
    localparam int CH_IDX_W = $clog2(CH_NUM);
    localparam int MODE_W   = BYTE_W - CH_IDX_W;
    localparam int NBYTES   = WORD_W / BYTE_W;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_state_t;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADDR,
        OP_CNT,
        OP_CMD,
        OP_REQ,
        OP_SMASK,
        OP_MODE,
        OP_CLRPTR,
        OP_MCLR,
        OP_CLRMASK,
        OP_MASKALL
    } op_t;

    localparam logic [SEL_W-1:0] OFS_STAT    = 4'd8;
    localparam logic [SEL_W-1:0] OFS_REQ     = 4'd9;
    localparam logic [SEL_W-1:0] OFS_SMASK   = 4'd10;
    localparam logic [SEL_W-1:0] OFS_MODE    = 4'd11;
    localparam logic [SEL_W-1:0] OFS_CLRPTR  = 4'd12;
    localparam logic [SEL_W-1:0] OFS_MCLR    = 4'd13;
    localparam logic [SEL_W-1:0] OFS_CLRMASK = 4'd14;
    localparam logic [SEL_W-1:0] OFS_MASKALL = 4'd15;

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr
    import dma_reg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic force_lo,
    output logic ptr_high
);

    ptr_state_t state_q;
    ptr_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PTR_LO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_LO: begin
                if (force_lo) begin
                    state_d = PTR_LO;
                end else if (step) begin
                    state_d = PTR_HI;
                end
            end
            PTR_HI: begin
                if (force_lo || step) begin
                    state_d = PTR_LO;
                end
            end
        endcase
    end

    always_comb begin
        ptr_high = (state_q == PTR_HI);
    end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              ptr_high,
    input  logic [BYTE_W-1:0] wdata,
    output logic [WORD_W-1:0] addr_q,
    output logic [WORD_W-1:0] cnt_q
);

    localparam int BSEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [BSEL_W-1:0] byte_idx;

    always_comb begin
        byte_idx = BSEL_W'(ptr_high);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_addr) begin
                addr_q[byte_idx*BYTE_W +: BYTE_W] <= wdata;
            end
            if (wr_cnt) begin
                cnt_q[byte_idx*BYTE_W +: BYTE_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import dma_reg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  op_t                      op,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [CH_NUM-1:0]        mask_q,
    output logic [CH_NUM-1:0]        req_q,
    output logic [CH_NUM*MODE_W-1:0] mode_flat
);

    logic [MODE_W-1:0]   mode_q [CH_NUM];
    logic [CH_IDX_W-1:0] ch;
    logic                flag;

    always_comb begin
        ch   = wdata[CH_IDX_W-1:0];
        flag = wdata[CH_IDX_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            req_q  <= '0;
            for (int i = 0; i < CH_NUM; i++) begin
                mode_q[i] <= '0;
            end
        end else begin
            unique case (op)
                OP_SMASK:   mask_q[ch] <= flag;
                OP_MODE:    mode_q[ch] <= wdata[BYTE_W-1:CH_IDX_W];
                OP_CLRMASK: mask_q     <= '0;
                OP_MASKALL: mask_q     <= wdata[CH_NUM-1:0];
                OP_REQ:     req_q[ch]  <= flag;
                OP_MCLR: begin
                    mask_q <= '1;
                    req_q  <= '0;
                end
                default: ;
            endcase
        end
    end

    genvar g;
    generate
        for (g = 0; g < CH_NUM; g++) begin : g_mode
            assign mode_flat[g*MODE_W +: MODE_W] = mode_q[g];
        end
    endgenerate

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_reg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         sel,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [BYTE_W-1:0]        rdata,
    output logic [CH_NUM*WORD_W-1:0] cur_addr,
    output logic [CH_NUM*WORD_W-1:0] cur_cnt,
    output logic [CH_NUM*MODE_W-1:0] mode_out,
    output logic [CH_NUM-1:0]        mask_out
);

    op_t                 wr_op;
    logic                is_word_port;
    logic [CH_IDX_W-1:0] port_ch;
    logic                ptr_step;
    logic                ptr_clr;
    logic                ptr_high;
    logic [CH_NUM-1:0]   req_bits;
    logic [WORD_W-1:0]   addr_arr [CH_NUM];
    logic [WORD_W-1:0]   cnt_arr  [CH_NUM];
    logic [WORD_W-1:0]   rd_word;

    always_comb begin
        is_word_port = !sel[SEL_W-1];
        port_ch      = sel[CH_IDX_W:1];
    end

    always_comb begin
        wr_op = OP_NONE;
        if (wr_en) begin
            if (is_word_port) begin
                wr_op = sel[0] ? OP_CNT : OP_ADDR;
            end else begin
                unique case (sel)
                    OFS_STAT:    wr_op = OP_CMD;
                    OFS_REQ:     wr_op = OP_REQ;
                    OFS_SMASK:   wr_op = OP_SMASK;
                    OFS_MODE:    wr_op = OP_MODE;
                    OFS_CLRPTR:  wr_op = OP_CLRPTR;
                    OFS_MCLR:    wr_op = OP_MCLR;
                    OFS_CLRMASK: wr_op = OP_CLRMASK;
                    OFS_MASKALL: wr_op = OP_MASKALL;
                    default:     wr_op = OP_NONE;
                endcase
            end
        end
    end

    always_comb begin
        ptr_step = (wr_en || rd_en) && is_word_port;
        ptr_clr  = (wr_op == OP_CLRPTR) || (wr_op == OP_MCLR);
    end

    dma_byte_ptr i_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (ptr_step),
        .force_lo (ptr_clr),
        .ptr_high (ptr_high)
    );

    genvar g;
    generate
        for (g = 0; g < CH_NUM; g++) begin : g_ch
            logic hit;
            assign hit = (port_ch == CH_IDX_W'(g));

            dma_chan_regs i_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_addr  ((wr_op == OP_ADDR) && hit),
                .wr_cnt   ((wr_op == OP_CNT) && hit),
                .ptr_high (ptr_high),
                .wdata    (wdata),
                .addr_q   (addr_arr[g]),
                .cnt_q    (cnt_arr[g])
            );

            assign cur_addr[g*WORD_W +: WORD_W] = addr_arr[g];
            assign cur_cnt[g*WORD_W +: WORD_W]  = cnt_arr[g];
        end
    endgenerate

    dma_ctrl_regs i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (wr_op),
        .wdata     (wdata),
        .mask_q    (mask_out),
        .req_q     (req_bits),
        .mode_flat (mode_out)
    );

    always_comb begin
        rd_word = sel[0] ? cnt_arr[port_ch] : addr_arr[port_ch];
        rdata   = '0;
        if (rd_en && !wr_en) begin
            if (is_word_port) begin
                rdata = ptr_high ? rd_word[WORD_W-1 -: BYTE_W] : rd_word[BYTE_W-1:0];
            end else if (sel == OFS_STAT) begin
                rdata = {req_bits, {(BYTE_W-CH_NUM){1'b0}}};
            end
        end
    end

endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
    import dma_reg_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic [SEL_W-1:0]         sel,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic [BYTE_W-1:0]        wdata,
    input logic                     ptr_high,
    input logic [CH_NUM*WORD_W-1:0] cur_addr,
    input logic [CH_NUM*MODE_W-1:0] mode_out,
    input logic [CH_NUM-1:0]        mask_out
);

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == OFS_CLRPTR)) |=> !ptr_high); // R5

    AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && !sel[SEL_W-1]) |=> (ptr_high != $past(ptr_high))); // R4

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en || rd_en) || (sel[SEL_W-1] && !(wr_en && (sel == OFS_CLRPTR || sel == OFS_MCLR))))
        |=> $stable(ptr_high)); // R12

    AST_MCLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == OFS_MCLR)) |=> (mask_out == '1 && !ptr_high && $stable(cur_addr))); // R10

    AST_CLRMASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == OFS_CLRMASK)) |=> (mask_out == '0)); // R8

    AST_MASKALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == OFS_MASKALL)) |=> (mask_out == $past(wdata[CH_NUM-1:0]))); // R9

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cur_addr)); // R2

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (sel == OFS_MODE)) |=> $stable(mode_out)); // R7

endmodule

bind dma_regfile dma_regfile_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .ptr_high (ptr_high),
    .cur_addr (cur_addr),
    .mode_out (mode_out),
    .mask_out (mask_out)
);

// File: tb/test_dma_regfile.sv
module test_dma_regfile;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sel = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [63:0] cur_addr;
    logic [63:0] cur_cnt;
    logic [23:0] mode_out;
    logic [3:0]  mask_out;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_regfile i_dma_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .cur_addr (cur_addr),
        .cur_cnt  (cur_cnt),
        .mode_out (mode_out),
        .mask_out (mask_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] s, output logic [7:0] d);
        @(negedge clk);
        sel = s; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 mask", mask_out, 4'hF);
        check("R1 addr", cur_addr, 64'h0);
        check("R1 cnt", cur_cnt, 64'h0);
        check("R1 mode", mode_out, 24'h0);
        rd(4'd8, d);
        check("R1 status", d, 8'h00);
        wr(4'd0, 8'h5A);
        check("R1 pointer low", cur_addr[15:0], 16'h005A);
        wr(4'd12, 8'h00);
    endtask

    task automatic t_word_rw();
        logic [7:0] lo, hi;
        wr(4'd12, 8'h00);
        wr(4'd4, 8'hEF); wr(4'd4, 8'hBE);
        check("R2 addr ch2", cur_addr[47:32], 16'hBEEF);
        wr(4'd7, 8'h34); wr(4'd7, 8'h12);
        check("R2 cnt ch3", cur_cnt[63:48], 16'h1234);
        check("R2 other ch", cur_addr[31:16], 16'h0);
        rd(4'd4, lo); rd(4'd4, hi);
        check("R3 read addr ch2", {hi, lo}, 16'hBEEF);
        rd(4'd7, lo); rd(4'd7, hi);
        check("R3 read cnt ch3", {hi, lo}, 16'h1234);
    endtask

    task automatic t_shared_ptr();
        logic [7:0] d;
        wr(4'd12, 8'h00);
        wr(4'd0, 8'h11);
        wr(4'd3, 8'h22);
        check("R4 ch0 addr low", cur_addr[15:0], 16'h0011);
        check("R4 ch1 cnt high", cur_cnt[31:16], 16'h2200);
        rd(4'd4, d);
        rd(4'd5, d);
        check("R4 read after read is high", d, 8'h00);
        wr(4'd2, 8'h77);
        check("R4 write after two reads low", cur_addr[31:16], 16'h0077);
        wr(4'd12, 8'h00);
    endtask

    task automatic t_clr_ptr();
        wr(4'd12, 8'h00);
        wr(4'd6, 8'hAA);
        wr(4'd12, 8'hFF);
        wr(4'd6, 8'hBB);
        check("R5 clear with data FF", cur_addr[63:48], 16'h00BB);
        wr(4'd6, 8'hCC);
        check("R5 then high", cur_addr[63:48], 16'hCCBB);
    endtask

    task automatic t_mask();
        wr(4'd15, 8'h0F);
        wr(4'd10, 8'h01);
        check("R6 unmask ch1", mask_out, 4'hD);
        wr(4'd10, 8'h05);
        check("R6 mask ch1", mask_out, 4'hF);
        wr(4'd14, 8'h5A);
        check("R8 clear mask", mask_out, 4'h0);
        wr(4'd10, 8'h06);
        check("R6 mask ch2 only", mask_out, 4'h4);
        wr(4'd15, 8'hFA);
        check("R9 mask all", mask_out, 4'hA);
    endtask

    task automatic t_mode();
        wr(4'd11, 8'b0101_1010);
        check("R7 mode ch2", mode_out, 24'h16 << 12);
        wr(4'd11, 8'b1100_0011);
        check("R7 mode ch3", mode_out, (24'h30 << 18) | (24'h16 << 12));
    endtask

    task automatic t_req_mclr();
        logic [7:0] d;
        wr(4'd9, 8'h06);
        wr(4'd9, 8'h04);
        rd(4'd8, d);
        check("R11 status", d, 8'h50);
        wr(4'd9, 8'h02);
        rd(4'd8, d);
        check("R11 request clear", d, 8'h10);
        wr(4'd14, 8'h00);
        wr(4'd12, 8'h00);
        wr(4'd1, 8'h99);
        wr(4'd13, 8'h00);
        check("R10 mask set", mask_out, 4'hF);
        check("R10 addr kept", cur_addr[47:32], 16'hBEEF);
        check("R10 mode kept", mode_out, (24'h30 << 18) | (24'h16 << 12));
        rd(4'd8, d);
        check("R10 requests cleared", d, 8'h00);
        wr(4'd1, 8'h44);
        check("R10 pointer low", cur_cnt[15:0], 16'h0044);
        wr(4'd12, 8'h00);
    endtask

    task automatic t_misc();
        logic [7:0] d;
        wr(4'd12, 8'h00);
        wr(4'd0, 8'h01);
        rd(4'd13, d);
        check("R12 temp read", d, 8'h00);
        wr(4'd8, 8'hFF);
        rd(4'd8, d);
        wr(4'd0, 8'h80);
        check("R12 pointer unmoved", cur_addr[15:0], 16'h8001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_rw();
        t_shared_ptr();
        t_clr_ptr();
        t_mask();
        t_mode();
        t_req_mclr();
        t_misc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule